// File: doc/BRIEF.md
# UART Receive Buffer with Hysteresis Flow Control

This block is the receive-side character store of one serial channel. The receive shift logic hands it one character per write strobe, together with three per-character error flags. The block queues these 11-bit entries in arrival order and hands them out one per read strobe. It keeps a fill count from which it derives a data-ready status bit and a level-reached status. When FIFO mode and the receive interrupt enable are both set, that level-reached status also drives a receive interrupt.

For automatic pacing of the far-end transmitter, the block drives an active-low request-to-send style output. That output is released (driven high) once the fill count climbs to the trigger level plus a programmable hysteresis. It is asserted (driven low) again once the count sinks to the trigger level minus the hysteresis. This keeps the remote side from being switched on and off at every character near the trigger point. The error flags of the character waiting at the head are presented continuously, so they can be placed in the line-status bits [4:2] of the channel.

Top module: `uart_rx_buffer`

## Requirements
- R1: Entries come out in the order they were written. Each entry is 8 data bits plus 3 error bits, and up to DEPTH (64) entries are held. The data bits of a popped entry appear on `rd_data` in the cycle after the `rd_en` edge that pops it, and `rd_data` keeps that value until the next pop.
- R2: `head_err` shows the 3 error bits of the entry at the head of the queue, and reads 0 while the queue is empty.
- R3: `fill_level` goes up by one on an accepted write and down by one on a pop. A write and a pop in the same cycle leave it unchanged. A read while empty leaves both `fill_level` and `rd_data` unchanged.
- R4: `rx_lvl_hit` is 1 exactly when `fill_level` is greater than or equal to `trig_lvl`.
- R5: `rx_irq` is 1 exactly when `rx_lvl_hit`, `fifo_mode_en` and `rx_irq_en` are all 1.
- R6: `data_ready` is 1 from the cycle after the first accepted write until the cycle after the queue becomes empty.
- R7: While `flow_feat_en` and `flow_modem_en` are both 1, `rts_n` goes to 1 at the first edge at which the new fill count is at least min(`trig_lvl`+`hyst`, 64). This rule takes priority over R8.
- R8: While flow control is enabled, `rts_n` goes to 0 at the first edge at which the new fill count is at most max(`trig_lvl`-`hyst`, 0). Between the two thresholds, `rts_n` keeps its previous value.
- R9: When either flow enable is 0, `rts_n` is 0 after the next edge.
- R10: A write while the queue is full, with no pop in the same cycle, is dropped and sets the sticky `overrun` flag. The flag clears on a `status_rd` cycle, and a new overrun in that same cycle wins over the clear.
- R11: Reset, or a `fifo_clr` cycle, empties the queue and clears `overrun`, `data_ready`, `rx_lvl_hit` (when `trig_lvl` > 0) and `rx_irq`, and drives `rts_n` to 0. Across a `fifo_clr`, `rd_data` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue clear |
| wr_en | input | 1 | Write strobe from the receive shift logic |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the received character |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 8 | Last popped character |
| head_err | output | 3 | Error flags of the head entry (line-status bits [4:2]) |
| status_rd | input | 1 | Status read strobe, clears overrun |
| fifo_mode_en | input | 1 | FIFO mode enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| flow_feat_en | input | 1 | Enhanced-feature enable for automatic flow control |
| flow_modem_en | input | 1 | Modem-control enable for automatic flow control |
| trig_lvl | input | 7 | Trigger level, 0 to 64 |
| hyst | input | 7 | Hysteresis around the trigger level |
| fill_level | output | 7 | Current number of entries |
| data_ready | output | 1 | At least one entry is held |
| rx_lvl_hit | output | 1 | Fill level has reached the trigger |
| rx_irq | output | 1 | Receive-data interrupt |
| overrun | output | 1 | Sticky overflow flag |
| rts_n | output | 1 | Active-low flow-control output |

## Verification
The bench uses the default depth of 64. This is the real queue size, so the trigger-plus-hysteresis arithmetic runs up against its saturation at 64 and its floor at 0. Random phases draw the trigger from 0 to 64 and the hysteresis from 0 to 16, and they skew the write and read rates so that the queue drains empty, fills to overflow, and hovers inside the hysteresis band. Directed sequences cover the 48/8 example (release at 56, assert at 40), overflow and clearing on status read, reads of an empty queue, and a clear from full.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxb_storage.sv
module rxb_storage
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push_req,
    input  logic              pop_req,
    input  rx_entry_t         wr_entry,
    output rx_entry_t         head_entry,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count_q_o,
    output logic [CW-1:0]     count_d_o,
    output logic              drop
);

    typedef struct packed {
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     rd_ptr;
        logic [CW-1:0]     count;
        logic [DATA_W-1:0] rd_data;
    } stor_t;

    stor_t     st_d, st_q;
    rx_entry_t mem [DEPTH];
    logic      do_push, do_pop, is_full, is_empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        is_empty = (st_q.count == '0);
        is_full  = (st_q.count == CW'(DEPTH));
        do_pop   = pop_req && !is_empty && !clr;
        do_push  = push_req && !clr && (!is_full || do_pop);
        drop     = push_req && !clr && !do_push;

        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (do_push) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (do_pop) begin
                st_d.rd_ptr  = bump(st_q.rd_ptr);
                st_d.rd_data = mem[st_q.rd_ptr].data;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= wr_entry;
    end

    assign head_entry = mem[st_q.rd_ptr];
    assign rd_data    = st_q.rd_data;
    assign count_q_o  = st_q.count;
    assign count_d_o  = st_d.count;

endmodule

// File: rtl/rxb_level.sv
module rxb_level
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CW-1:0]    count,
    input  logic [CW-1:0]    trig,
    input  logic             mode_en,
    input  logic             irq_en,
    input  logic             drop,
    input  logic             status_rd,
    input  logic [ERR_W-1:0] head_err_raw,
    output logic [ERR_W-1:0] head_err,
    output logic             lvl_hit,
    output logic             irq,
    output logic             data_ready,
    output logic             overrun
);

    typedef struct packed {
        logic ovr;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)            st_d.ovr = 1'b0;
        else if (drop)      st_d.ovr = 1'b1;
        else if (status_rd) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_ready = (count != '0);
    assign lvl_hit    = (count >= trig);
    assign irq        = lvl_hit && mode_en && irq_en;
    assign overrun    = st_q.ovr;
    assign head_err   = data_ready ? head_err_raw : '0;

endmodule

// File: rtl/rxb_flow.sv
module rxb_flow #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int TW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          feat_en,
    input  logic          modem_en,
    input  logic [CW-1:0] count_next,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] hyst,
    output logic          rts_n
);

    typedef struct packed {
        logic hold_off;
    } flow_t;

    flow_t         st_d, st_q;
    logic [TW-1:0] sum_w;
    logic [CW-1:0] upper, lower;
    logic          active;

    always_comb begin
        sum_w  = {1'b0, trig} + {1'b0, hyst};
        upper  = (sum_w > TW'(DEPTH)) ? CW'(DEPTH) : sum_w[CW-1:0];
        lower  = (hyst >= trig) ? '0 : trig - hyst;
        active = feat_en && modem_en;

        st_d = st_q;
        if (clr || !active)            st_d.hold_off = 1'b0;
        else if (count_next >= upper)  st_d.hold_off = 1'b1;
        else if (count_next <= lower)  st_d.hold_off = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rts_n = st_q.hold_off;

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  head_err,
    input  logic              status_rd,
    input  logic              fifo_mode_en,
    input  logic              rx_irq_en,
    input  logic              flow_feat_en,
    input  logic              flow_modem_en,
    input  logic [CW-1:0]     trig_lvl,
    input  logic [CW-1:0]     hyst,
    output logic [CW-1:0]     fill_level,
    output logic              data_ready,
    output logic              rx_lvl_hit,
    output logic              rx_irq,
    output logic              overrun,
    output logic              rts_n
);

    rx_entry_t     in_entry, head_entry;
    logic [CW-1:0] count_next;
    logic          drop;

    assign in_entry = '{err: wr_err, data: wr_data};

    rxb_storage #(.DEPTH(DEPTH)) u_stor (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push_req   (wr_en),
        .pop_req    (rd_en),
        .wr_entry   (in_entry),
        .head_entry (head_entry),
        .rd_data    (rd_data),
        .count_q_o  (fill_level),
        .count_d_o  (count_next),
        .drop       (drop)
    );

    rxb_level #(.DEPTH(DEPTH)) u_lvl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (fifo_clr),
        .count        (fill_level),
        .trig         (trig_lvl),
        .mode_en      (fifo_mode_en),
        .irq_en       (rx_irq_en),
        .drop         (drop),
        .status_rd    (status_rd),
        .head_err_raw (head_entry.err),
        .head_err     (head_err),
        .lvl_hit      (rx_lvl_hit),
        .irq          (rx_irq),
        .data_ready   (data_ready),
        .overrun      (overrun)
    );

    rxb_flow #(.DEPTH(DEPTH)) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .feat_en    (flow_feat_en),
        .modem_en   (flow_modem_en),
        .count_next (count_next),
        .trig       (trig_lvl),
        .hyst       (hyst),
        .rts_n      (rts_n)
    );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          status_rd,
    input logic          fifo_mode_en,
    input logic          rx_irq_en,
    input logic          flow_feat_en,
    input logic          flow_modem_en,
    input logic [CW-1:0] fill_level,
    input logic          data_ready,
    input logic          rx_irq,
    input logic          overrun,
    input logic          rts_n
);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    p_push_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fifo_clr) |=> data_ready);

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (fifo_mode_en && rx_irq_en));

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd && !fifo_clr) |=> overrun);

    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == CW'(DEPTH) && wr_en && !rd_en && !fifo_clr)
            |=> (fill_level == CW'(DEPTH) && overrun));

    p_flow_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flow_feat_en && flow_modem_en) |=> !rts_n);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fill_level == '0 && !rts_n && !overrun));

endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_clr      (fifo_clr),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .status_rd     (status_rd),
    .fifo_mode_en  (fifo_mode_en),
    .rx_irq_en     (rx_irq_en),
    .flow_feat_en  (flow_feat_en),
    .flow_modem_en (flow_modem_en),
    .fill_level    (fill_level),
    .data_ready    (data_ready),
    .rx_irq        (rx_irq),
    .overrun       (overrun),
    .rts_n         (rts_n)
);

// File: tb/sim_uart_rx_buffer.sv
`timescale 1ns/1ps
module sim_uart_rx_buffer;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, status_rd = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [2:0]    wr_err = '0;
    logic          fifo_mode_en = 1'b0, rx_irq_en = 1'b0;
    logic          flow_feat_en = 1'b0, flow_modem_en = 1'b0;
    logic [CW-1:0] trig_lvl = '0, hyst = '0;
    logic [7:0]    rd_data;
    logic [2:0]    head_err;
    logic [CW-1:0] fill_level;
    logic          data_ready, rx_lvl_hit, rx_irq, overrun, rts_n;

    uart_rx_buffer #(.DEPTH(DEPTH)) u0 (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // bench configuration, applied to the ports at the next step
    int b_trig = 0, b_hyst = 0;
    bit b_mode = 0, b_ie = 0, b_fe = 0, b_me = 0;

    // reference model state
    logic [10:0] mq[$];
    logic [7:0]  m_rd = '0;
    bit          m_ovr = 0;
    bit          m_rts = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int upper_thr(input int t, input int h);
        return (t + h > DEPTH) ? DEPTH : t + h;
    endfunction

    function automatic int lower_thr(input int t, input int h);
        return (h >= t) ? 0 : t - h;
    endfunction

    task automatic compare();
        int sz = mq.size();
        chk("R3 fill_level", fill_level, sz);
        chk("R6 data_ready", data_ready, sz != 0);
        chk("R4 rx_lvl_hit", rx_lvl_hit, sz >= b_trig);
        chk("R5 rx_irq", rx_irq, (sz >= b_trig) && b_mode && b_ie);
        chk("R7 R8 R9 rts_n", rts_n, m_rts);
        chk("R10 overrun", overrun, m_ovr);
        chk("R1 rd_data", rd_data, m_rd);
        chk("R2 head_err", head_err, sz != 0 ? int'(mq[0][10:8]) : 0);
    endtask

    task automatic step(input bit w, input bit r, input bit clr, input bit srd,
                        input logic [10:0] ent);
        bit pop, push;
        int sz;
        @(negedge clk);
        wr_en = w; rd_en = r; fifo_clr = clr; status_rd = srd;
        wr_data = ent[7:0]; wr_err = ent[10:8];
        trig_lvl = CW'(b_trig); hyst = CW'(b_hyst);
        fifo_mode_en = b_mode; rx_irq_en = b_ie;
        flow_feat_en = b_fe; flow_modem_en = b_me;
        if (clr) begin
            mq.delete();
            m_ovr = 0;
            m_rts = 0;
        end else begin
            pop  = r && mq.size() > 0;
            push = w && (mq.size() < DEPTH || pop);
            if (pop) m_rd = mq.pop_front() & 11'h0FF;
            if (push) mq.push_back(ent);
            if (w && !push) m_ovr = 1;
            else if (srd)   m_ovr = 0;
            sz = mq.size();
            if (!(b_fe && b_me))                    m_rts = 0;
            else if (sz >= upper_thr(b_trig, b_hyst)) m_rts = 1;
            else if (sz <= lower_thr(b_trig, b_hyst)) m_rts = 0;
        end
        @(posedge clk);
        #1;
        compare();
    endtask

    function automatic logic [10:0] rnd_ent();
        return 11'($urandom);
    endfunction

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 reset fill", fill_level, 0);
        chk("R11 reset ready", data_ready, 0);
        chk("R11 reset rts_n", rts_n, 0);
        chk("R11 reset overrun", overrun, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 R8: trigger 48, hysteresis 8
        b_trig = 48; b_hyst = 8; b_mode = 1; b_ie = 1; b_fe = 1; b_me = 1;
        for (int i = 0; i < 55; i++) step(1, 0, 0, 0, rnd_ent());
        chk("R7 still asserted at 55", rts_n, 0);
        chk("R5 irq at 55", rx_irq, 1);
        step(1, 0, 0, 0, rnd_ent());
        chk("R7 released at 56", rts_n, 1);
        for (int i = 0; i < 15; i++) step(0, 1, 0, 0, '0);
        chk("R8 held at 41", rts_n, 1);
        step(0, 1, 0, 0, '0);
        chk("R8 reasserted at 40", rts_n, 0);
        chk("R4 below trigger", rx_lvl_hit, 0);

        // R10: overflow, dropped write, clear on status read
        b_fe = 0;
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, rnd_ent());
        chk("R10 full", fill_level, DEPTH);
        step(1, 0, 0, 0, 11'h7AA);
        chk("R10 overrun set", overrun, 1);
        step(1, 1, 0, 0, 11'h555);
        chk("R3 push+pop at full", fill_level, DEPTH);
        step(0, 0, 0, 1, '0);
        chk("R10 cleared by status read", overrun, 0);
        chk("R9 flow disabled", rts_n, 0);

        // R3: drain then read empty
        while (mq.size() > 0) step(0, 1, 0, 0, '0);
        step(0, 1, 0, 0, '0);
        step(0, 1, 0, 0, '0);
        chk("R3 empty read count", fill_level, 0);
        chk("R6 ready cleared", data_ready, 0);

        // R11: clear from full with flow active
        b_trig = 60; b_hyst = 10; b_fe = 1;
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, rnd_ent());
        chk("R7 saturated upper", rts_n, 1);
        step(1, 0, 1, 0, rnd_ent());
        chk("R11 clear fill", fill_level, 0);
        chk("R11 clear rts_n", rts_n, 0);

        // random phases
        for (int ph = 0; ph < 40; ph++) begin
            int wp = $urandom_range(10, 90);
            int rp = $urandom_range(10, 90);
            b_trig = $urandom_range(0, DEPTH);
            b_hyst = $urandom_range(0, 16);
            b_mode = ($urandom_range(0, 3) != 0);
            b_ie   = ($urandom_range(0, 3) != 0);
            b_fe   = ($urandom_range(0, 4) != 0);
            b_me   = ($urandom_range(0, 4) != 0);
            for (int i = 0; i < 100; i++) begin
                step($urandom_range(0, 99) < wp, $urandom_range(0, 99) < rp,
                     $urandom_range(0, 199) == 0, $urandom_range(0, 19) == 0,
                     rnd_ent());
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule